// File: doc/BRIEF.md
# Tagged Token Pairing Stage

This block sits between the token network and instruction fetch in a tagged-token dataflow pipeline. Each arriving token carries a context number, an instruction address, an operand side (left or right) and a data word. A two-operand instruction may fire only when both of its operands are present. The block keeps tokens that are still waiting for a partner in a small fully associative store. The store is keyed on context and instruction address together, so that separate loop iterations or calls of the same instruction never pair with each other.

When an arriving token finds its partner, the block frees the waiting entry. It then presents both operands in one registered output beat, left operand first, with the shared context and address. When no partner is waiting, the token is written into a free entry and a one-cycle bubble marker is raised instead of an output beat. A token flagged as feeding a one-operand instruction skips the store entirely. The input uses a valid/ready handshake that back-pressures only when a token needs a free entry and none is left, or when the output beat is stalled. The output uses a valid/ready handshake as well.

Top module: `tok_match_unit`

## Requirements
- R1: After reset the store is empty, `out_valid`, `out_bubble` and `err_dup` are 0 and `in_ready` is 1. A token whose key was waiting before the reset finds no partner afterwards.
- R2: An accepted two-operand token with no waiting entry of equal context and address is stored. In the cycle after the accepting edge, `out_bubble` is 1 and `out_valid` is 0.
- R3: An accepted two-operand token that meets a waiting entry with equal context and address and the opposite side (`in_side` 0 = left, 1 = right) produces one output beat. That beat carries the shared context and address, `out_left` holding the left-side data and `out_right` the right-side data, whichever arrived first.
- R4: Tokens with the same instruction address but different context never pair.
- R5: A completed pair frees its entry, so a later token with the same key is stored again and raises a bubble.
- R6: A token with `in_mono` = 1 is emitted at once with `out_mono` = 1, its data on `out_left` and `out_right` = 0. The store is left untouched.
- R7: With all 16 entries occupied, a token that would need an entry sees `in_ready` = 0. A token that completes a pair is still accepted, and it frees an entry.
- R8: A token whose key and side equal a waiting entry raises `err_dup` for one cycle and is dropped. The waiting entry keeps its original data.
- R9: While `out_valid` = 1 and `out_ready` = 0, the output beat is held unchanged and `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Arriving token present |
| in_ready | output | 1 | Token accepted on this edge when valid |
| in_ctx | input | CTX_W (6) | Context number of the token |
| in_ip | input | IP_W (10) | Instruction address of the token |
| in_side | input | 1 | Operand side: 0 left, 1 right |
| in_mono | input | 1 | Token feeds a one-operand instruction |
| in_data | input | DATA_W (16) | Operand value |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the beat |
| out_ctx | output | CTX_W (6) | Context of the fired instruction |
| out_ip | output | IP_W (10) | Address of the fired instruction |
| out_mono | output | 1 | Beat comes from a one-operand token |
| out_left | output | DATA_W (16) | Left operand |
| out_right | output | DATA_W (16) | Right operand (0 for one-operand beats) |
| out_bubble | output | 1 | One-cycle marker: token was stored, no beat |
| err_dup | output | 1 | One-cycle marker: duplicate side dropped |

## Verification
The two functions that meet in one cycle are a completed pair that frees an entry and the full-store back-pressure that would refuse the same token. To provoke the case, all sixteen entries are filled. The bench first checks that a key-missing token is refused at the port. It then presents the partner of one waiting entry and expects acceptance with a correct pair beat. A following key-missing token must then be accepted into the freed entry with a bubble. A second overlap, a stalled output beat meeting a new arrival, is judged by holding `out_ready` low and checking that the beat stays stable while `in_ready` stays low.

// File: rtl/tmu_pkg.sv
// Shared types for the token pairing stage.
// Assumes: side encoding 0 = left operand, 1 = right operand.
package tmu_pkg;

    typedef enum logic {
        SIDE_LEFT  = 1'b0,
        SIDE_RIGHT = 1'b1
    } side_e;

    typedef enum logic [2:0] {
        ACT_STORE,
        ACT_PAIR,
        ACT_DUP,
        ACT_MONO
    } act_e;

endpackage

// File: rtl/tmu_store.sv
// Waiting-token storage: one register slot per entry with a valid bit.
// Assumes: wr_idx addresses a free slot when wr_en is set; clr_vec marks
// at most the slot that just paired. A clear and a write never hit the same slot.
module tmu_store #(
    parameter int DEPTH  = 16,
    parameter int KEY_W  = 16,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [KEY_W-1:0]               wr_key,
    input  logic                           wr_side,
    input  logic [DATA_W-1:0]              wr_data,
    input  logic [DEPTH-1:0]               clr_vec,
    output logic [DEPTH-1:0]               vld,
    output logic [DEPTH-1:0][KEY_W-1:0]    keys,
    output logic [DEPTH-1:0]               sides,
    output logic [DEPTH-1:0][DATA_W-1:0]   datas
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // Per-slot valid: cleared on pairing, set on a fresh store.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld[g] <= 1'b0;
            end else if (clr_vec[g]) begin
                vld[g] <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                vld[g] <= 1'b1;
            end
        end

        // Per-slot payload: captured only when this slot is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                keys[g]  <= '0;
                sides[g] <= 1'b0;
                datas[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                keys[g]  <= wr_key;
                sides[g] <= wr_side;
                datas[g] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/tmu_cam.sv
// Associative lookup: compares the probe key against every valid slot and
// returns the hit vector plus the side and data of the hitting slot.
// Assumes: at most one valid slot holds any key, so AND-OR read-out is exact.
module tmu_cam #(
    parameter int DEPTH  = 16,
    parameter int KEY_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic [DEPTH-1:0]               vld,
    input  logic [DEPTH-1:0][KEY_W-1:0]    keys,
    input  logic [DEPTH-1:0]               sides,
    input  logic [DEPTH-1:0][DATA_W-1:0]   datas,
    input  logic [KEY_W-1:0]               probe,
    output logic [DEPTH-1:0]               hit_vec,
    output logic                           hit_side,
    output logic [DATA_W-1:0]              hit_data
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit_vec[g] = vld[g] && (keys[g] == probe);
    end

    // AND-OR read-out of the hitting slot's side and data.
    always_comb begin
        hit_side = 1'b0;
        hit_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (hit_vec[i]) begin
                hit_side = hit_side | sides[i];
                hit_data = hit_data | datas[i];
            end
        end
    end

endmodule

// File: rtl/tmu_free_pick.sv
// Free-slot picker: lowest-numbered empty slot and a full flag.
// Assumes: nothing beyond a valid vector from the store.
module tmu_free_pick #(
    parameter int DEPTH  = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]  vld,
    output logic [IDX_W-1:0]  free_idx,
    output logic              full
);

    // Scan from the top so the lowest empty slot wins.
    always_comb begin
        free_idx = '0;
        full     = 1'b1;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                free_idx = IDX_W'(i);
                full     = 1'b0;
            end
        end
    end

endmodule

// File: rtl/tok_match_unit.sv
// Token pairing stage of a tagged-token dataflow pipeline.
// Pairs two-operand tokens on {context, instruction address}, stores
// unmatched ones and raises a bubble marker. It drops duplicate sides with
// an error pulse and passes one-operand tokens straight through. The
// output is one registered beat with a valid/ready handshake.
// Assumes: producers keep at most one token per key and side in flight;
// a second one is reported and dropped.
module tok_match_unit #(
    parameter int CTX_W  = 6,
    parameter int IP_W   = 10,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    localparam int KEY_W = CTX_W + IP_W,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [CTX_W-1:0]  in_ctx,
    input  logic [IP_W-1:0]   in_ip,
    input  logic              in_side,
    input  logic              in_mono,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [CTX_W-1:0]  out_ctx,
    output logic [IP_W-1:0]   out_ip,
    output logic              out_mono,
    output logic [DATA_W-1:0] out_left,
    output logic [DATA_W-1:0] out_right,
    output logic              out_bubble,
    output logic              err_dup
);
    import tmu_pkg::*;

    logic [KEY_W-1:0]             probe_key;
    logic [DEPTH-1:0]             vld_vec;
    logic [DEPTH-1:0][KEY_W-1:0]  key_arr;
    logic [DEPTH-1:0]             side_arr;
    logic [DEPTH-1:0][DATA_W-1:0] data_arr;
    logic [DEPTH-1:0]             hit_vec;
    logic                         hit;
    logic                         hit_side;
    logic [DATA_W-1:0]            hit_data;
    logic [IDX_W-1:0]             free_idx;
    logic                         full;
    act_e                         act;
    logic                         slot_ok;
    logic                         accept;
    logic [DATA_W-1:0]            pair_left;
    logic [DATA_W-1:0]            pair_right;

    assign probe_key = {in_ctx, in_ip};
    assign hit       = |hit_vec;

    tmu_store #(.DEPTH(DEPTH), .KEY_W(KEY_W), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (accept && (act == ACT_STORE)),
        .wr_idx  (free_idx),
        .wr_key  (probe_key),
        .wr_side (in_side),
        .wr_data (in_data),
        .clr_vec ((accept && (act == ACT_PAIR)) ? hit_vec : '0),
        .vld     (vld_vec),
        .keys    (key_arr),
        .sides   (side_arr),
        .datas   (data_arr)
    );

    tmu_cam #(.DEPTH(DEPTH), .KEY_W(KEY_W), .DATA_W(DATA_W)) u_cam (
        .vld      (vld_vec),
        .keys     (key_arr),
        .sides    (side_arr),
        .datas    (data_arr),
        .probe    (probe_key),
        .hit_vec  (hit_vec),
        .hit_side (hit_side),
        .hit_data (hit_data)
    );

    tmu_free_pick #(.DEPTH(DEPTH)) u_pick (
        .vld      (vld_vec),
        .free_idx (free_idx),
        .full     (full)
    );

    // Classify the arriving token into one of the four actions.
    always_comb begin
        if (in_mono)                act = ACT_MONO;
        else if (!hit)              act = ACT_STORE;
        else if (hit_side == in_side) act = ACT_DUP;
        else                        act = ACT_PAIR;
    end

    // Input handshake: output slot must drain; a store needs a free entry.
    assign slot_ok  = !out_valid || out_ready;
    assign in_ready = slot_ok && !((act == ACT_STORE) && full);
    assign accept   = in_valid && in_ready;

    // Order operands left then right independent of arrival order.
    always_comb begin
        if (in_side == SIDE_LEFT) begin
            pair_left  = in_data;
            pair_right = hit_data;
        end else begin
            pair_left  = hit_data;
            pair_right = in_data;
        end
    end

    // Output beat register: loads on pair or pass-through, clears on drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_ctx   <= '0;
            out_ip    <= '0;
            out_mono  <= 1'b0;
            out_left  <= '0;
            out_right <= '0;
        end else if (accept && (act == ACT_PAIR || act == ACT_MONO)) begin
            out_valid <= 1'b1;
            out_ctx   <= in_ctx;
            out_ip    <= in_ip;
            out_mono  <= (act == ACT_MONO);
            out_left  <= (act == ACT_MONO) ? in_data : pair_left;
            out_right <= (act == ACT_MONO) ? '0 : pair_right;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // One-cycle markers for stored tokens and dropped duplicates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_bubble <= 1'b0;
            err_dup    <= 1'b0;
        end else begin
            out_bubble <= accept && (act == ACT_STORE);
            err_dup    <= accept && (act == ACT_DUP);
        end
    end

endmodule

// File: rtl/tok_match_unit_chk.sv
// Property checker for the token pairing stage, bound to every instance.
// Assumes: connected to the top's ports and its store valid vector,
// full flag and hit flag.
module tok_match_unit_chk #(
    parameter int DEPTH  = 16,
    parameter int CTX_W  = 6,
    parameter int IP_W   = 10,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_mono,
    input logic              out_valid,
    input logic              out_ready,
    input logic [CTX_W-1:0]  out_ctx,
    input logic [IP_W-1:0]   out_ip,
    input logic              out_mono,
    input logic [DATA_W-1:0] out_left,
    input logic [DATA_W-1:0] out_right,
    input logic              out_bubble,
    input logic              err_dup,
    input logic [DEPTH-1:0]  vld_vec,
    input logic              full,
    input logic              hit
);

    logic was_rst;

    // Remember whether the previous edge saw reset asserted.
    always_ff @(posedge clk) begin
        was_rst <= !rst_n;
    end

    // R1
    always_ff @(posedge clk) begin
        if (was_rst && rst_n) begin
            reset_state_chk: assert (!out_valid && !out_bubble && !err_dup && (vld_vec == '0));
        end
    end

    // R2
    bubble_no_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_bubble |-> !out_valid);

    // R6
    mono_right_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_mono) |-> (out_right == '0));

    // R7
    full_backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && in_valid && !hit && !in_mono) |-> !in_ready);

    // R8
    dup_keeps_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_dup |-> (vld_vec == $past(vld_vec)));

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_left) && $stable(out_right)
                                       && $stable(out_ctx) && $stable(out_ip)));

    // R9
    stall_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

endmodule

bind tok_match_unit tok_match_unit_chk #(
    .DEPTH(DEPTH), .CTX_W(CTX_W), .IP_W(IP_W), .DATA_W(DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_mono    (in_mono),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_ctx    (out_ctx),
    .out_ip     (out_ip),
    .out_mono   (out_mono),
    .out_left   (out_left),
    .out_right  (out_right),
    .out_bubble (out_bubble),
    .err_dup    (err_dup),
    .vld_vec    (vld_vec),
    .full       (full),
    .hit        (hit)
);

// File: tb/test_tok_match_unit.sv
// Bench for the token pairing stage: a vector table walked by one loop,
// then directed tests for reset, full store, output stall and reset clearing.
module test_tok_match_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [5:0]  in_ctx = '0;
    logic [9:0]  in_ip = '0;
    logic        in_side = 1'b0;
    logic        in_mono = 1'b0;
    logic [15:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [5:0]  out_ctx;
    logic [9:0]  out_ip;
    logic        out_mono;
    logic [15:0] out_left;
    logic [15:0] out_right;
    logic        out_bubble;
    logic        err_dup;

    int vecs = 0;
    int fails = 0;

    always #10 clk = ~clk;

    tok_match_unit i_tok_match_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_ctx(in_ctx), .in_ip(in_ip), .in_side(in_side), .in_mono(in_mono),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_ctx(out_ctx), .out_ip(out_ip), .out_mono(out_mono),
        .out_left(out_left), .out_right(out_right), .out_bubble(out_bubble),
        .err_dup(err_dup)
    );

    // kind: 0 stored (bubble), 1 pair, 2 duplicate dropped, 3 one-operand
    typedef struct packed {
        logic [5:0]  ctx;
        logic [9:0]  ip;
        logic        side;
        logic        mono;
        logic [15:0] data;
        logic [1:0]  kind;
        logic [15:0] l;
        logic [15:0] r;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{6'd1, 10'd5, 1'b0, 1'b0, 16'hAAAA, 2'd0, 16'h0000, 16'h0000, 8'd2},
        '{6'd1, 10'd5, 1'b1, 1'b0, 16'hBBBB, 2'd1, 16'hAAAA, 16'hBBBB, 8'd3},
        '{6'd2, 10'd7, 1'b1, 1'b0, 16'h1111, 2'd0, 16'h0000, 16'h0000, 8'd2},
        '{6'd2, 10'd7, 1'b0, 1'b0, 16'h2222, 2'd1, 16'h2222, 16'h1111, 8'd3},
        '{6'd3, 10'd9, 1'b0, 1'b0, 16'h3333, 2'd0, 16'h0000, 16'h0000, 8'd2},
        '{6'd4, 10'd9, 1'b1, 1'b0, 16'h4444, 2'd0, 16'h0000, 16'h0000, 8'd4},
        '{6'd3, 10'd9, 1'b0, 1'b0, 16'h5555, 2'd2, 16'h0000, 16'h0000, 8'd8},
        '{6'd3, 10'd9, 1'b1, 1'b0, 16'h6666, 2'd1, 16'h3333, 16'h6666, 8'd8},
        '{6'd4, 10'd9, 1'b0, 1'b0, 16'h7777, 2'd1, 16'h7777, 16'h4444, 8'd4},
        '{6'd1, 10'd5, 1'b1, 1'b0, 16'h8888, 2'd0, 16'h0000, 16'h0000, 8'd5},
        '{6'd5, 10'd3, 1'b0, 1'b1, 16'h9999, 2'd3, 16'h9999, 16'h0000, 8'd6},
        '{6'd1, 10'd5, 1'b0, 1'b0, 16'h0001, 2'd1, 16'h0001, 16'h8888, 8'd6}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Present one token at a negedge; returns at the next negedge.
    task automatic put(input logic [5:0] c, input logic [9:0] a, input logic s,
                       input logic m, input logic [15:0] d);
        in_ctx = c; in_ip = a; in_side = s; in_mono = m; in_data = d;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: reset state
        check("R1", "out_valid", {31'd0, out_valid}, 32'd0);
        check("R1", "out_bubble", {31'd0, out_bubble}, 32'd0);
        check("R1", "err_dup", {31'd0, err_dup}, 32'd0);
        check("R1", "in_ready", {31'd0, in_ready}, 32'd1);

        // Table walk: R2 R3 R4 R5 R6 R8
        for (int k = 0; k < NV; k++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[k].req);
            put(VECS[k].ctx, VECS[k].ip, VECS[k].side, VECS[k].mono, VECS[k].data);
            check(tag, "out_valid", {31'd0, out_valid},
                  {31'd0, (VECS[k].kind == 2'd1 || VECS[k].kind == 2'd3)});
            check(tag, "out_bubble", {31'd0, out_bubble}, {31'd0, (VECS[k].kind == 2'd0)});
            check(tag, "err_dup", {31'd0, err_dup}, {31'd0, (VECS[k].kind == 2'd2)});
            if (VECS[k].kind == 2'd1 || VECS[k].kind == 2'd3) begin
                check(tag, "out_left", {16'd0, out_left}, {16'd0, VECS[k].l});
                check(tag, "out_right", {16'd0, out_right}, {16'd0, VECS[k].r});
                check(tag, "out_key", {16'd0, out_ctx, out_ip}, {16'd0, VECS[k].ctx, VECS[k].ip});
                check(tag, "out_mono", {31'd0, out_mono}, {31'd0, VECS[k].mono});
            end
        end

        // R7: fill all entries, then full-store refusal and pairing while full
        do_reset();
        for (int i = 0; i < 16; i++) begin
            put(6'd0, 10'(i), 1'b0, 1'b0, 16'h1000 + 16'(i));
        end
        in_ctx = 6'd0; in_ip = 10'd100; in_side = 1'b0; in_mono = 1'b0;
        in_data = 16'hDEAD; in_valid = 1'b1;
        #1;
        check("R7", "in_ready full miss", {31'd0, in_ready}, 32'd0);
        in_valid = 1'b0;
        @(negedge clk);
        check("R7", "no beat while refused", {31'd0, out_valid}, 32'd0);
        in_ctx = 6'd0; in_ip = 10'd3; in_side = 1'b1; in_data = 16'hC0DE; in_valid = 1'b1;
        #1;
        check("R7", "in_ready full hit", {31'd0, in_ready}, 32'd1);
        @(negedge clk);
        in_valid = 1'b0;
        check("R7", "pair while full", {31'd0, out_valid}, 32'd1);
        check("R7", "left while full", {16'd0, out_left}, 32'h1003);
        check("R7", "right while full", {16'd0, out_right}, 32'hC0DE);
        put(6'd0, 10'd100, 1'b0, 1'b0, 16'hDEAD);
        check("R7", "freed entry takes miss", {31'd0, out_bubble}, 32'd1);

        // R9: stalled output beat
        do_reset();
        out_ready = 1'b0;
        put(6'd7, 10'd20, 1'b1, 1'b0, 16'h00F0);
        put(6'd7, 10'd20, 1'b0, 1'b0, 16'h000F);
        check("R9", "beat presented", {31'd0, out_valid}, 32'd1);
        in_ctx = 6'd8; in_ip = 10'd21; in_mono = 1'b1; in_side = 1'b0;
        in_data = 16'h0ABC; in_valid = 1'b1;
        #1;
        check("R9", "in_ready stalled", {31'd0, in_ready}, 32'd0);
        @(negedge clk);
        @(negedge clk);
        check("R9", "held valid", {31'd0, out_valid}, 32'd1);
        check("R9", "held left", {16'd0, out_left}, 32'h000F);
        check("R9", "held right", {16'd0, out_right}, 32'h00F0);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        in_mono = 1'b0;
        check("R9", "next beat after drain", {31'd0, out_mono}, 32'd1);
        check("R9", "next beat data", {16'd0, out_left}, 32'h0ABC);

        // R1: reset discards waiting tokens
        put(6'd9, 10'd30, 1'b0, 1'b0, 16'h5A5A);
        do_reset();
        put(6'd9, 10'd30, 1'b1, 1'b0, 16'hA5A5);
        check("R1", "no pair after reset", {31'd0, out_valid}, 32'd0);
        check("R1", "stored after reset", {31'd0, out_bubble}, 32'd1);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

endmodule